// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates two groups of free-running clocks that come from a clock synthesizer: a group of CPU clock outputs and a group of PCI clock outputs. One further PCI output is not gated by its group's stop request. Three active-low requests control the gating: a CPU stop, a PCI stop and a power-down. Each group has its own timing rule. The CPU stop and the power-down are asynchronous, so they pass through a synchronizer in the CPU clock domain. The PCI stop is sampled on the rising edge of the PCI clock and applied one PCI cycle later.

Each gate enable changes only on the falling edge of its clock, while the clock is low. A gated output therefore never produces a runt pulse. It finishes the high phase it has started, rests LOW once stopped, and restarts with a complete high phase. The power-down request also stops the free PCI output, under the same finish-the-cycle rule. The block sits between the synthesizer core and the output buffers. Clock generation, frequency choice and output levels are outside its scope.

Top module: `clock_stop_ctrl`

## Requirements
- R1: While rstN is low, every output is LOW. After rstN rises with all requests high, the first CPU pulse appears on the third cpuClk rising edge after the release. The first free and gated PCI pulses appear on the third pciClk rising edge after the release.
- R2: A change of cpuStopN, made away from a clock edge, first takes effect on the third cpuClk rising edge after the change. That is 2 to 3 CPU cycles later, and the rule holds for both stopping and restarting. Stopped CPU outputs rest LOW.
- R3: Every high pulse on any output lasts exactly half the period of its source clock. Every low phase lasts at least half that period.
- R4: pciStopN is captured on each pciClk rising edge. A change first takes effect on the second pciClk rising edge after the change.
- R5: While the captured pciStopN is LOW, all gated PCI outputs are held at 0. While it is HIGH and power is up, they follow pciClk.
- R6: pciFreeOut follows pciClk whatever the value of pciStopN.
- R7: A change of pwrDwnN takes effect on the third cpuClk rising edge for the CPU outputs and on the third pciClk rising edge for all PCI outputs, the free one included. Stopped outputs rest LOW. Restarted outputs begin with a full pulse.
- R8: All CPU outputs carry the same waveform, and all gated PCI outputs carry the same waveform.
- R9: cpuStopN has no effect on any PCI output, and pciStopN has no effect on any CPU output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpuClk | input | 1 | free-running CPU source clock |
| pciClk | input | 1 | free-running PCI source clock |
| rstN | input | 1 | asynchronous active-low reset |
| cpuStopN | input | 1 | active-low CPU group stop request, asynchronous |
| pciStopN | input | 1 | active-low PCI group stop request, sampled on pciClk |
| pwrDwnN | input | 1 | active-low power-down request, asynchronous |
| cpuOut | output | NUM_CPU (2) | gated CPU clock outputs |
| pciOut | output | NUM_PCI (5) | gated PCI clock outputs |
| pciFreeOut | output | 1 | PCI output that pciStopN does not gate |

## Verification
The bench builds the block with NUM_CPU=2, NUM_PCI=5 and SYNC_STAGES=2. These values give the 2-to-3-cycle CPU window and the third-edge power-down timing on both domains, and they give enough replicated gates to show that a group stays coherent. The PCI clock runs at one third of the CPU rate, with a phase offset, so request changes land at many points within each domain's cycle. This lets the bench measure stop and start latency both in edges and in nanoseconds, and measure every pulse width on an output of each group.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  // run requests from the control logic to the gating datapath
  typedef struct packed {
    logic cpuRun;
    logic pciGatedRun;
    logic pciFreeRun;
  } gateReq_t;
endpackage

// File: rtl/clk_stop_ctl.sv
`timescale 1ns/1ps
module clk_stop_ctl
  import clk_stop_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     cpuClk,
  input  logic     pciClk,
  input  logic     rstN,
  input  logic     cpuStopN,
  input  logic     pciStopN,
  input  logic     pwrDwnN,
  output gateReq_t req
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] cpuStopSyncQ;
  logic [MSB:0] cpuPwrSyncQ;
  logic [MSB:0] pciPwrSyncQ;
  logic         pciStopQ;

  // asynchronous requests enter the CPU domain through a flop chain
  always_ff @(posedge cpuClk or negedge rstN) begin
    if (!rstN) begin
      cpuStopSyncQ <= '0;
      cpuPwrSyncQ  <= '0;
    end else begin
      cpuStopSyncQ <= {cpuStopSyncQ[MSB-1:0], cpuStopN};
      cpuPwrSyncQ  <= {cpuPwrSyncQ[MSB-1:0], pwrDwnN};
    end
  end

  // PCI stop is a plain capture; power-down is synchronized here too
  always_ff @(posedge pciClk or negedge rstN) begin
    if (!rstN) begin
      pciStopQ    <= 1'b0;
      pciPwrSyncQ <= '0;
    end else begin
      pciStopQ    <= pciStopN;
      pciPwrSyncQ <= {pciPwrSyncQ[MSB-1:0], pwrDwnN};
    end
  end

  assign req.cpuRun      = cpuStopSyncQ[MSB] & cpuPwrSyncQ[MSB];
  assign req.pciGatedRun = pciStopQ & pciPwrSyncQ[MSB];
  assign req.pciFreeRun  = pciPwrSyncQ[MSB];

  // R4: the captured stop equals the request seen one PCI edge earlier
  a_r4_pci_capture: assert property (@(posedge pciClk) disable iff (!rstN)
    $past(rstN) |-> (pciStopQ == $past(pciStopN)));

  generate
    if (SYNC_STAGES == 2) begin : g_depthChecks
      // R2: CPU run request lags the combined inputs by two CPU edges
      a_r2_cpu_sync_depth: assert property (@(posedge cpuClk) disable iff (!rstN)
        ($past(rstN) && $past(rstN, 2)) |-> (req.cpuRun == $past(cpuStopN && pwrDwnN, 2)));
      // R7: PCI-side power request lags pwrDwnN by two PCI edges
      a_r7_pci_pwr_depth: assert property (@(posedge pciClk) disable iff (!rstN)
        ($past(rstN) && $past(rstN, 2)) |-> (req.pciFreeRun == $past(pwrDwnN, 2)));
    end
  endgenerate
endmodule

// File: rtl/clk_gate_dp.sv
`timescale 1ns/1ps
module clk_gate_dp
  import clk_stop_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int NUM_PCI = 5
) (
  input  logic               cpuClk,
  input  logic               pciClk,
  input  logic               rstN,
  input  gateReq_t           req,
  output logic [NUM_CPU-1:0] cpuOut,
  output logic [NUM_PCI-1:0] pciOut,
  output logic               pciFreeOut
);
  // one falling-edge enable per output: it only moves while its clock is low
  generate
    for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpuGate
      logic enQ;
      always_ff @(negedge cpuClk or negedge rstN) begin
        if (!rstN) enQ <= 1'b0;
        else       enQ <= req.cpuRun;
      end
      assign cpuOut[g] = cpuClk & enQ;

      // R2: the enable seen at a rising edge is the request held before it
      a_r2_en_follows_req: assert property (@(posedge cpuClk) disable iff (!rstN)
        enQ == req.cpuRun);
    end

    for (genvar g = 0; g < NUM_PCI; g++) begin : g_pciGate
      logic enQ;
      always_ff @(negedge pciClk or negedge rstN) begin
        if (!rstN) enQ <= 1'b0;
        else       enQ <= req.pciGatedRun;
      end
      assign pciOut[g] = pciClk & enQ;

      // R5: gated PCI enable follows the captured stop request
      a_r5_en_follows_req: assert property (@(posedge pciClk) disable iff (!rstN)
        enQ == req.pciGatedRun);
    end
  endgenerate

  logic freeEnQ;
  always_ff @(negedge pciClk or negedge rstN) begin
    if (!rstN) freeEnQ <= 1'b0;
    else       freeEnQ <= req.pciFreeRun;
  end
  assign pciFreeOut = pciClk & freeEnQ;

  // R8: the replicated gates of one group never disagree during a high phase
  a_r8_cpu_coherent: assert property (@(negedge cpuClk) disable iff (!rstN)
    (cpuOut == '0) || (cpuOut == '1));
  a_r8_pci_coherent: assert property (@(negedge pciClk) disable iff (!rstN)
    (pciOut == '0) || (pciOut == '1));
  // R6: a gated PCI pulse is never present without the free pulse
  a_r6_free_covers_gated: assert property (@(negedge pciClk) disable iff (!rstN)
    (|pciOut) |-> pciFreeOut);
endmodule

// File: rtl/clock_stop_ctrl.sv
`timescale 1ns/1ps
module clock_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int NUM_CPU     = 2,
  parameter int NUM_PCI     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               cpuClk,
  input  logic               pciClk,
  input  logic               rstN,
  input  logic               cpuStopN,
  input  logic               pciStopN,
  input  logic               pwrDwnN,
  output logic [NUM_CPU-1:0] cpuOut,
  output logic [NUM_PCI-1:0] pciOut,
  output logic               pciFreeOut
);
  gateReq_t req;

  clk_stop_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_ctl (
    .cpuClk   (cpuClk),
    .pciClk   (pciClk),
    .rstN     (rstN),
    .cpuStopN (cpuStopN),
    .pciStopN (pciStopN),
    .pwrDwnN  (pwrDwnN),
    .req      (req)
  );

  clk_gate_dp #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI)) u_dp (
    .cpuClk     (cpuClk),
    .pciClk     (pciClk),
    .rstN       (rstN),
    .req        (req),
    .cpuOut     (cpuOut),
    .pciOut     (pciOut),
    .pciFreeOut (pciFreeOut)
  );
endmodule

// File: tb/clock_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clock_stop_ctrl_bench;
  localparam int      NUM_CPU      = 2;
  localparam int      NUM_PCI      = 5;
  localparam realtime CPU_HALF     = 2.5;
  localparam realtime PCI_HALF     = 7.5;
  localparam int      CPU_EFF      = 3;
  localparam int      PCI_STOP_EFF = 2;
  localparam int      PCI_PWR_EFF  = 3;

  logic cpuClk = 1'b0, pciClk = 1'b0, rstN = 1'b0;
  logic cpuStopN = 1'b1, pciStopN = 1'b1, pwrDwnN = 1'b1;
  logic [NUM_CPU-1:0] cpuOut;
  logic [NUM_PCI-1:0] pciOut;
  logic pciFreeOut;

  int checks = 0, errors = 0;
  bit done = 0;
  bit mCpuStop = 1, mPciStop = 1, mPwr = 1;

  clock_stop_ctrl #(.NUM_CPU(NUM_CPU), .NUM_PCI(NUM_PCI), .SYNC_STAGES(2)) u_clock_stop_ctrl (
    .cpuClk(cpuClk), .pciClk(pciClk), .rstN(rstN), .cpuStopN(cpuStopN),
    .pciStopN(pciStopN), .pwrDwnN(pwrDwnN), .cpuOut(cpuOut), .pciOut(pciOut),
    .pciFreeOut(pciFreeOut)
  );

  always #(CPU_HALF) cpuClk = ~cpuClk;
  initial begin
    #1;
    forever #(PCI_HALF) pciClk = ~pciClk;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected model values
  function automatic bit expAt(input int k, input int eff, input bit oldV, input bit newV);
    return (k >= eff) ? newV : oldV;
  endfunction
  function automatic bit expCpu();
    return mCpuStop & mPwr;
  endfunction
  function automatic bit expGated();
    return mPciStop & mPwr;
  endfunction

  // R3 pulse-width monitors
  realtime cRise = -1.0, cFall = -100.0, gRise = -1.0, gFall = -100.0, fRise = -1.0, fFall = -100.0;
  always @(posedge cpuOut[0]) begin
    chk(($realtime - cFall) >= CPU_HALF - 0.01, "R3", "cpu low phase x10", int'(($realtime - cFall) * 10.0), 25);
    cRise = $realtime;
  end
  always @(negedge cpuOut[0]) begin
    if (cRise >= 0.0)
      chk((($realtime - cRise) > CPU_HALF - 0.01) && (($realtime - cRise) < CPU_HALF + 0.01),
          "R3", "cpu high width x10", int'(($realtime - cRise) * 10.0), 25);
    cFall = $realtime;
  end
  always @(posedge pciOut[0]) begin
    chk(($realtime - gFall) >= PCI_HALF - 0.01, "R3", "pci low phase x10", int'(($realtime - gFall) * 10.0), 75);
    gRise = $realtime;
  end
  always @(negedge pciOut[0]) begin
    if (gRise >= 0.0)
      chk((($realtime - gRise) > PCI_HALF - 0.01) && (($realtime - gRise) < PCI_HALF + 0.01),
          "R3", "pci high width x10", int'(($realtime - gRise) * 10.0), 75);
    gFall = $realtime;
  end
  always @(posedge pciFreeOut) begin
    chk(($realtime - fFall) >= PCI_HALF - 0.01, "R3", "free low phase x10", int'(($realtime - fFall) * 10.0), 75);
    fRise = $realtime;
  end
  always @(negedge pciFreeOut) begin
    if (fRise >= 0.0)
      chk((($realtime - fRise) > PCI_HALF - 0.01) && (($realtime - fRise) < PCI_HALF + 0.01),
          "R3", "free high width x10", int'(($realtime - fRise) * 10.0), 75);
    fFall = $realtime;
  end

  // CPU outputs across a change made at time t0
  task automatic cpuSeq(input bit oldV, input bit newV, input realtime t0, input string tag);
    for (int k = 1; k <= 5; k++) begin
      @(posedge cpuClk);
      #1;
      chk(cpuOut === {NUM_CPU{expAt(k, CPU_EFF, oldV, newV)}}, tag, "cpu level at edge",
          int'(cpuOut), expAt(k, CPU_EFF, oldV, newV));
      chk((cpuOut == '0) || (cpuOut == '1), "R8", "cpu group coherent", int'(cpuOut), 0);
      if (k == CPU_EFF && oldV != newV)
        chk(($realtime - 1.0 - t0) >= 2.0 * 2.0 * CPU_HALF && ($realtime - 1.0 - t0) <= 3.0 * 2.0 * CPU_HALF,
            "R2", "cpu latency x10 within 100..150", int'(($realtime - 1.0 - t0) * 10.0), 150);
    end
  endtask

  task automatic pciSeq(input int eff, input bit gOld, input bit gNew, input bit fOld, input bit fNew,
                        input string gTag, input string fTag);
    for (int k = 1; k <= eff + 2; k++) begin
      @(posedge pciClk);
      #1;
      chk(pciOut === {NUM_PCI{expAt(k, eff, gOld, gNew)}}, gTag, "gated pci level",
          int'(pciOut), expAt(k, eff, gOld, gNew));
      chk((pciOut == '0) || (pciOut == '1), "R8", "pci group coherent", int'(pciOut), 0);
      chk(pciFreeOut === expAt(k, eff, fOld, fNew), fTag, "free pci level",
          int'(pciFreeOut), expAt(k, eff, fOld, fNew));
    end
  endtask

  task automatic cpuHold(input bit lvl, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge cpuClk);
      #1;
      chk(cpuOut === {NUM_CPU{lvl}}, tag, "cpu unaffected", int'(cpuOut), lvl);
    end
  endtask

  task automatic pciHold(input bit g, input bit f, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(posedge pciClk);
      #1;
      chk(pciOut === {NUM_PCI{g}} && pciFreeOut === f, tag, "pci unaffected",
          int'({pciFreeOut, pciOut}), int'({f, {NUM_PCI{g}}}));
    end
  endtask

  task automatic doCpu(input bit v);
    bit oldC;
    realtime t0;
    oldC = expCpu();
    @(negedge cpuClk);
    #(0.2 + 0.1 * $urandom_range(0, 20));
    cpuStopN = v;
    mCpuStop = v;
    t0 = $realtime;
    fork
      cpuSeq(oldC, expCpu(), t0, "R2");
      pciHold(expGated(), mPwr, 3, "R9");
    join
  endtask

  task automatic doPci(input bit v);
    bit oldG;
    oldG = expGated();
    @(negedge pciClk);
    #(0.2 + 0.1 * $urandom_range(0, 68));
    pciStopN = v;
    mPciStop = v;
    fork
      pciSeq(PCI_STOP_EFF, oldG, expGated(), mPwr, mPwr, "R4 R5", "R6");
      cpuHold(expCpu(), 6, "R9");
    join
  endtask

  task automatic doPwr(input bit v);
    bit oldC, oldG, oldF;
    realtime t0;
    oldC = expCpu();
    oldG = expGated();
    oldF = mPwr;
    @(negedge cpuClk);
    #(0.2 + 1.0 * $urandom_range(0, 2));
    pwrDwnN = v;
    mPwr = v;
    t0 = $realtime;
    fork
      cpuSeq(oldC, expCpu(), t0, "R7");
      pciSeq(PCI_PWR_EFF, oldG, expGated(), oldF, mPwr, "R7", "R7");
    join
  endtask

  initial begin
    int seedVal;
    realtime tRel;
    seedVal = $urandom(32'd20240611);
    // R1: everything low while reset is held
    repeat (4) begin
      @(posedge cpuClk);
      #1;
      chk(cpuOut == '0 && pciOut == '0 && pciFreeOut == 1'b0, "R1", "outputs in reset",
          int'({pciFreeOut, pciOut, cpuOut}), 0);
    end
    @(negedge cpuClk);
    #0.3;
    rstN = 1'b1;
    tRel = $realtime;
    fork
      cpuSeq(1'b0, 1'b1, tRel, "R1");
      pciSeq(PCI_PWR_EFF, 1'b0, 1'b1, 1'b0, 1'b1, "R1", "R1");
    join
    // directed corners
    doCpu(1'b0);
    doCpu(1'b1);
    doPci(1'b0);
    doPci(1'b1);
    doPwr(1'b0);
    doCpu(1'b0);
    doPci(1'b0);
    doCpu(1'b1);
    doPwr(1'b1);
    doPci(1'b1);
    doPci(1'b0);
    doPwr(1'b0);
    doPwr(1'b1);
    doPci(1'b1);
    // random mix
    for (int i = 0; i < 30; i++) begin
      case ($urandom_range(0, 2))
        0: doCpu(~mCpuStop);
        1: doPci(~mPciStop);
        default: doPwr(~mPwr);
      endcase
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000.0 * 2.0 * CPU_HALF);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule